// File: doc/BRIEF.md
# SPI FIFO Multi-Item Access Adapter

This block sits between a memory-mapped register port and the transmit and receive FIFOs of an SPI controller. It lets one register access move several characters at once. A write splits the bus word into one or two FIFO pushes. A read gathers up to four FIFO entries into one right-aligned read word. The number of items moved depends on three things: the access size, the configured character width, and whether packing is enabled for that direction.

Transmit packing is enabled when the transmit threshold setting is nonzero and the controller uses a fixed peripheral select. Receive unpacking is enabled when the receive threshold setting is nonzero and the controller runs as a client rather than as master. The FIFOs stay outside the block. The transmit FIFO is seen as a two-lane push port plus a fill level. The receive FIFO is seen as a four-entry peek window, oldest entry first, plus a pop count and a fill level. Every access completes in its own cycle. Read data is registered and appears one cycle later.

Top module: `spi_mdata_adapter`

## Requirements
- R1: Transmit packing is active only when `cfg_tx_th` is nonzero and `cfg_var_sel` is 0. Otherwise every write asks for exactly one push.
- R2: Receive unpacking is active only when `cfg_rx_th` is nonzero and `cfg_master` is 0. Otherwise every read pops at most one item.
- R3: A byte access (`bus_size`=0) moves at most one item. A byte write pushes `{8'h00, bus_wdata[7:0]}` on lane 0.
- R4: A halfword access (`bus_size`=1) writes one item, `bus_wdata[15:0]`. A halfword read pops up to two items when unpacking is active and `cfg_wide`=0, and one item otherwise.
- R5: A word write (`bus_size`=2) with packing pushes `bus_wdata[15:0]` on lane 0 (first) and `bus_wdata[31:16]` on lane 1. Without packing it pushes only `bus_wdata[15:0]`.
- R6: A word read with unpacking pops up to four items when `cfg_wide`=0, and up to two when `cfg_wide`=1. Without unpacking it pops up to one.
- R7: Read data is right-aligned with the oldest item in the lowest lane. Lanes are 8 bits wide, each holding item bits [7:0], when unpacking is active, `cfg_wide`=0 and the access is a halfword or word. In every other case, lanes are 16 bits and hold the whole item.
- R8: When the FIFO holds fewer items than the access could carry, only the available items are popped and the unused upper lanes read as zero. A read of an empty FIFO returns 0.
- R9: A push that finds the transmit FIFO full is dropped. Earlier lanes of the same access still go in, and `tx_ovf` sets and stays set until reset.
- R10: Pushes and pops are signalled in the cycle of the access and never without one. `bus_rdata` and `bus_rvalid` update on the next clock edge.
- R11: After reset, `bus_rdata` is 0, `bus_rvalid` is 0 and `tx_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_th | input | TH_W | Transmit threshold setting; nonzero allows packing |
| cfg_var_sel | input | 1 | 1 = variable peripheral select (blocks transmit packing) |
| cfg_rx_th | input | TH_W | Receive threshold setting; nonzero allows unpacking |
| cfg_master | input | 1 | 1 = master mode (blocks receive unpacking) |
| cfg_wide | input | 1 | 1 = characters wider than 8 bits |
| bus_wr | input | 1 | Write access strobe |
| bus_rd | input | 1 | Read access strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| tx_push_en | output | 2 | Per-lane push strobes, lane 0 oldest |
| tx_push_data | output | 32 | Lane data, 16 bits per lane |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_pop_cnt | output | 3 | Number of receive entries popped this cycle |
| rx_peek | input | 64 | Four oldest receive entries, 16 bits each, oldest in bits [15:0] |
| rx_level | input | LVL_W | Receive FIFO fill level |

## Verification
The assertions assume both fill levels never exceed the FIFO depths. They also assume `bus_size` never takes the reserved code 3, and that `rx_peek` entries at or beyond `rx_level` carry no meaning. The stimulus respects these limits because the bench's own queues drive the levels and the peek window, and it only ever issues sizes 0 to 2. Unused peek slots are filled with a nonzero pattern, so zero fill in the read word comes from the block's masking and not from the stimulus. Configuration changes happen only between accesses.

// File: rtl/spi_md_pkg.sv
package spi_md_pkg;
  localparam int BUS_W    = 32;
  localparam int ITEM_W   = 16;
  localparam int TX_LANES = 2;
  localparam int RX_LANES = 4;
  localparam int NARROW_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/spi_md_count.sv
module spi_md_count
  import spi_md_pkg::*;
#(
  parameter int TH_W = 2
) (
  input  logic [TH_W-1:0] tx_th,
  input  logic            var_sel,
  input  logic [TH_W-1:0] rx_th,
  input  logic            master,
  input  logic            wide,
  input  logic [1:0]      size,
  output logic [1:0]      tx_want,
  output logic [2:0]      rx_want,
  output logic            narrow_lanes,
  output logic            byte_acc
);
  logic      tx_pack;
  logic      rx_pack;
  acc_size_e sz;

  assign sz      = acc_size_e'(size);
  assign tx_pack = (tx_th != '0) && !var_sel;
  assign rx_pack = (rx_th != '0) && !master;

  always_comb begin
    tx_want      = 2'd0;
    rx_want      = 3'd0;
    narrow_lanes = 1'b0;
    byte_acc     = 1'b0;
    unique case (sz)
      SZ_BYTE: begin
        tx_want  = 2'd1;
        rx_want  = 3'd1;
        byte_acc = 1'b1;
      end
      SZ_HALF: begin
        tx_want      = 2'd1;
        rx_want      = (rx_pack && !wide) ? 3'd2 : 3'd1;
        narrow_lanes = rx_pack && !wide;
      end
      SZ_WORD: begin
        tx_want      = tx_pack ? 2'd2 : 2'd1;
        rx_want      = rx_pack ? (wide ? 3'd2 : 3'd4) : 3'd1;
        narrow_lanes = rx_pack && !wide;
      end
      default: begin
        tx_want = 2'd0;
        rx_want = 3'd0;
      end
    endcase
  end
endmodule

// File: rtl/spi_md_tx_split.sv
module spi_md_tx_split
  import spi_md_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [1:0]                 want,
  input  logic                       byte_acc,
  input  logic [BUS_W-1:0]           wdata,
  input  logic [LVL_W-1:0]           level,
  output logic [TX_LANES-1:0]        push_en,
  output logic [TX_LANES*ITEM_W-1:0] push_data,
  output logic                       ovf
);
  logic [LVL_W-1:0]    free;
  logic [TX_LANES-1:0] need;
  logic                drop;

  assign free = LVL_W'(DEPTH) - level;

  for (genvar i = 0; i < TX_LANES; i++) begin : g_lane
    assign need[i]    = wr && (want > 2'(i));
    assign push_en[i] = need[i] && (free > LVL_W'(i));
    if (i == 0) begin : g_first
      assign push_data[ITEM_W-1:0] = byte_acc ? {8'h00, wdata[7:0]} : wdata[ITEM_W-1:0];
    end else begin : g_rest
      assign push_data[i*ITEM_W +: ITEM_W] = wdata[i*ITEM_W +: ITEM_W];
    end
  end

  assign drop = |(need & ~push_en);

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (drop) ovf <= 1'b1;
  end

  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
    push_en[1] |-> push_en[0]); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R9
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (rst)
    LVL_W'($countones(push_en)) <= free); // R9
  AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr |-> push_en == '0); // R10
endmodule

// File: rtl/spi_md_rx_gather.sv
module spi_md_rx_gather
  import spi_md_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  logic [2:0]                 want,
  input  logic                       narrow,
  input  logic [RX_LANES*ITEM_W-1:0] peek,
  input  logic [LVL_W-1:0]           level,
  output logic [2:0]                 pop_cnt,
  output logic [BUS_W-1:0]           rdata,
  output logic                       rvalid
);
  localparam int CW = (LVL_W > 3) ? LVL_W : 3;
  localparam int WIDE_LANES = BUS_W / ITEM_W;

  logic [CW-1:0]    want_x;
  logic [CW-1:0]    lvl_x;
  logic [2:0]       avail;
  logic [BUS_W-1:0] narrow_word;
  logic [BUS_W-1:0] wide_word;

  assign want_x  = CW'(want);
  assign lvl_x   = CW'(level);
  assign avail   = 3'((want_x < lvl_x) ? want_x : lvl_x);
  assign pop_cnt = rd ? avail : 3'd0;

  for (genvar k = 0; k < RX_LANES; k++) begin : g_nlane
    assign narrow_word[k*NARROW_W +: NARROW_W] =
      (3'(k) < avail) ? peek[k*ITEM_W +: NARROW_W] : '0;
  end

  for (genvar k = 0; k < WIDE_LANES; k++) begin : g_wlane
    assign wide_word[k*ITEM_W +: ITEM_W] =
      (3'(k) < avail) ? peek[k*ITEM_W +: ITEM_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= narrow ? narrow_word : wide_word;
    end
  end

  AST_POP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_cnt) <= lvl_x); // R8
  AST_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd |-> pop_cnt == 3'd0); // R10
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid); // R10
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && level == '0) |=> rdata == '0); // R8
  AST_WIDE_MAX2: assert property (@(posedge clk) disable iff (rst)
    (rd && !narrow) |-> pop_cnt <= 3'd2); // R6
endmodule

// File: rtl/spi_mdata_adapter.sv
module spi_mdata_adapter
  import spi_md_pkg::*;
#(
  parameter int TH_W     = 2,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int LVL_W    = $clog2(((TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH) + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [TH_W-1:0]            cfg_tx_th,
  input  logic                       cfg_var_sel,
  input  logic [TH_W-1:0]            cfg_rx_th,
  input  logic                       cfg_master,
  input  logic                       cfg_wide,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [1:0]                 bus_size,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  output logic                       bus_rvalid,
  output logic [TX_LANES-1:0]        tx_push_en,
  output logic [TX_LANES*ITEM_W-1:0] tx_push_data,
  input  logic [LVL_W-1:0]           tx_level,
  output logic                       tx_ovf,
  output logic [2:0]                 rx_pop_cnt,
  input  logic [RX_LANES*ITEM_W-1:0] rx_peek,
  input  logic [LVL_W-1:0]           rx_level
);
  logic [1:0] tx_want;
  logic [2:0] rx_want;
  logic       narrow_lanes;
  logic       byte_acc;

  spi_md_count #(.TH_W(TH_W)) u_count (
    .tx_th        (cfg_tx_th),
    .var_sel      (cfg_var_sel),
    .rx_th        (cfg_rx_th),
    .master       (cfg_master),
    .wide         (cfg_wide),
    .size         (bus_size),
    .tx_want      (tx_want),
    .rx_want      (rx_want),
    .narrow_lanes (narrow_lanes),
    .byte_acc     (byte_acc)
  );

  spi_md_tx_split #(.DEPTH(TX_DEPTH), .LVL_W(LVL_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .want      (tx_want),
    .byte_acc  (byte_acc),
    .wdata     (bus_wdata),
    .level     (tx_level),
    .push_en   (tx_push_en),
    .push_data (tx_push_data),
    .ovf       (tx_ovf)
  );

  spi_md_rx_gather #(.DEPTH(RX_DEPTH), .LVL_W(LVL_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .want    (rx_want),
    .narrow  (narrow_lanes),
    .peek    (rx_peek),
    .level   (rx_level),
    .pop_cnt (rx_pop_cnt),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  AST_TX_UNPACKED_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_tx_th == '0 || cfg_var_sel) |-> !tx_push_en[1]); // R1
  AST_RX_MASTER_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_master || cfg_rx_th == '0) |-> rx_pop_cnt <= 3'd1); // R2
  AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (bus_size == 2'd0) |-> (rx_pop_cnt <= 3'd1 && !tx_push_en[1])); // R3
  AST_HALF_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (bus_size == 2'd1) |-> !tx_push_en[1]); // R4
endmodule

// File: tb/tb_spi_mdata_adapter.sv
module tb_spi_mdata_adapter;
  localparam int TXD = 8;
  localparam int RXD = 8;
  localparam int LW  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_tx_th = '0, cfg_rx_th = '0;
  logic        cfg_var_sel = 1'b0, cfg_master = 1'b0, cfg_wide = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  tx_push_en;
  logic [31:0] tx_push_data;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic        tx_ovf;
  logic [2:0]  rx_pop_cnt;
  logic [63:0] rx_peek = '0;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit eovf = 0;
  logic [15:0] txq[$];
  logic [15:0] rxq[$];

  always #5 clk = ~clk;

  spi_mdata_adapter dut (
    .clk(clk), .rst(rst), .cfg_tx_th(cfg_tx_th), .cfg_var_sel(cfg_var_sel),
    .cfg_rx_th(cfg_rx_th), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_push_en(tx_push_en),
    .tx_push_data(tx_push_data), .tx_level(tx_level), .tx_ovf(tx_ovf),
    .rx_pop_cnt(rx_pop_cnt), .rx_peek(rx_peek), .rx_level(rx_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access cycle checked against the queue-based model.
  task automatic step(input bit wr, input bit rd, input logic [1:0] sz,
                      input logic [31:0] wd, input string req);
    bit txp, rxp, nar;
    int twant, rwant, free, npush, npop;
    logic [1:0]  emask;
    logic [15:0] it0, it1;
    logic [31:0] erd;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_size = sz; bus_wdata = wd;
    tx_level = LW'(txq.size());
    rx_level = LW'(rxq.size());
    for (int k = 0; k < 4; k++)
      rx_peek[16*k +: 16] = (k < rxq.size()) ? rxq[k] : 16'hA5A5;
    #1;
    txp = (cfg_tx_th != 0) && !cfg_var_sel;
    rxp = (cfg_rx_th != 0) && !cfg_master;
    twant = (sz == 2 && txp) ? 2 : 1;
    rwant = (sz == 0) ? 1 : (sz == 1) ? ((rxp && !cfg_wide) ? 2 : 1)
                      : (rxp ? (cfg_wide ? 2 : 4) : 1);
    nar = rxp && !cfg_wide && sz != 0;
    free = TXD - txq.size();
    npush = wr ? ((twant < free) ? twant : free) : 0;
    if (wr && twant > free) eovf = 1;
    emask = (npush == 2) ? 2'b11 : (npush == 1) ? 2'b01 : 2'b00;
    it0 = (sz == 0) ? {8'h00, wd[7:0]} : wd[15:0];
    it1 = wd[31:16];
    chk({req, " push_en"}, 32'(tx_push_en), 32'(emask));
    if (emask[0]) chk({req, " lane0"}, 32'(tx_push_data[15:0]), 32'(it0));
    if (emask[1]) chk({req, " lane1"}, 32'(tx_push_data[31:16]), 32'(it1));
    npop = rd ? ((rwant < rxq.size()) ? rwant : rxq.size()) : 0;
    chk({req, " pop_cnt"}, 32'(rx_pop_cnt), 32'(npop));
    erd = '0;
    for (int k = 0; k < npop; k++) begin
      if (nar) erd[8*k +: 8] = rxq[k][7:0];
      else     erd[16*k +: 16] = rxq[k];
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < npush; k++) txq.push_back(k == 0 ? it0 : it1);
    for (int k = 0; k < npop; k++) void'(rxq.pop_front());
    if (rd) chk({req, " rdata"}, bus_rdata, erd);
    chk("R10 rvalid", 32'(bus_rvalid), 32'(rd));
    chk("R9 ovf", 32'(tx_ovf), 32'(eovf));
  endtask

  task automatic load_rx(input int n, input bit wide);
    for (int k = 0; k < n; k++)
      if (rxq.size() < RXD)
        rxq.push_back(wide ? 16'($urandom) : {8'h00, 8'($urandom)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 rdata", bus_rdata, 32'h0);
    chk("R11 rvalid", 32'(bus_rvalid), 32'h0);
    chk("R11 ovf", 32'(tx_ovf), 32'h0);
    @(negedge clk) rst = 1'b0;

    // R1: packing off (threshold zero), then blocked by variable select
    cfg_tx_th = 0;
    step(1, 0, 2, 32'h1234_5678, "R1 th0 word");
    cfg_tx_th = 2; cfg_var_sel = 1;
    step(1, 0, 2, 32'hAAAA_BBBB, "R1 varsel word");
    cfg_var_sel = 0;
    // R5 / R4 / R3 with packing on
    step(1, 0, 2, 32'hCAFE_0102, "R5 word pack");
    step(1, 0, 1, 32'hFFFF_4321, "R4 half write");
    step(1, 0, 0, 32'hFFFF_FF77, "R3 byte write");
    // R9: FIFO has one free slot, word write drops the high lane
    while (txq.size() < TXD - 1) step(1, 0, 0, 32'h11, "R9 fill");
    step(1, 0, 2, 32'h5555_6666, "R9 overflow");
    step(1, 0, 2, 32'h7777_8888, "R9 full");
    txq.delete();
    step(0, 0, 0, 0, "R9 sticky");

    // R6/R4/R7: six narrow items: word read then halfword read
    cfg_rx_th = 1; cfg_master = 0; cfg_wide = 0;
    load_rx(6, 0);
    step(0, 1, 2, 0, "R6 word narrow");
    step(0, 1, 1, 0, "R4 half narrow");
    load_rx(6, 0);
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0, "R3 byte read");
    load_rx(6, 0);
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0, "R7 half reads");
    // R2: master mode and zero threshold pop one
    load_rx(4, 0);
    cfg_master = 1;
    step(0, 1, 2, 0, "R2 master word");
    cfg_master = 0; cfg_rx_th = 0;
    step(0, 1, 2, 0, "R2 th0 word");
    cfg_rx_th = 3;
    rxq.delete();
    // R6/R7 wide
    cfg_wide = 1;
    load_rx(5, 1);
    step(0, 1, 2, 0, "R6 word wide");
    step(0, 1, 1, 0, "R7 half wide");
    step(0, 1, 0, 0, "R7 byte wide");
    rxq.delete();
    // R8: partial and empty
    cfg_wide = 0;
    load_rx(3, 0);
    step(0, 1, 2, 0, "R8 partial word");
    step(0, 1, 2, 0, "R8 empty word");

    // Mixed random traffic
    for (int c = 0; c < 600; c++) begin
      if (c % 60 == 0) begin
        cfg_tx_th = 2'($urandom); cfg_var_sel = 1'($urandom);
        cfg_rx_th = 2'($urandom); cfg_master = 1'($urandom);
        cfg_wide = 1'($urandom);
      end
      if ($urandom % 3 == 0) load_rx(1, cfg_wide);
      if ($urandom % 3 == 0 && txq.size() > 0) void'(txq.pop_front());
      step(1'($urandom), 1'($urandom), 2'($urandom % 3), $urandom, "R7 mixed");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule